// File: doc/BRIEF.md
# Chien Search Error Locator

This unit takes the error-locator polynomial of a binary BCH decode and finds the bit positions where errors sit. Software first pulses `dis` to clear the engine, writes the configuration word (polynomial degree and sector-size flag), then writes each coefficient by index. A pulse on `start` launches the search over `len_bits` candidate positions. The caller sets this length to the sector size in bits plus m·t, where m is the field width and t the correction capability. One position is tested per clock. Each coefficient sits in its own working register, and that register is multiplied by a fixed power of alpha on every step.

A position p counts as an error location when the polynomial evaluated at alpha^p is zero. Found positions are reported 1-based and in ascending order through an indexed readout. Subtracting one gives a bit index, whose byte is index/8 and whose bit is index mod 8. When the search completes, the root count is compared with the programmed degree. A mismatch means the sector cannot be corrected.

The controller has three states. `S_IDLE` is entered at reset and on `dis`. `S_RUN` is entered from any state on `start`, or straight to `S_DONE` when the length is zero. `S_RUN` moves to `S_DONE` when the last position has been tested. A new `start` leaves `S_DONE` for `S_RUN`, and `dis` returns every state to `S_IDLE`.

Top module: `chien_locator`

## Requirements
- R1: The configuration word carries the polynomial degree (number of coefficients minus one) in bits [20:16]. Bit 0 selects the 1024-byte sector field GF(2^14) with polynomial 0x4443. When bit 0 is clear, the field is GF(2^13) with polynomial 0x201B. Coefficients with an index above the degree are treated as zero.
- R2: A `dis` pulse takes effect one cycle later. It returns the engine to idle, clears all coefficients, zeroes the status word and clears every location entry. Reset gives the same state.
- R3: A `start` sampled at edge k latches `len_bits`, sets busy and tests positions 1..len, one per clock. Done rises after edge k+len. A zero length gives done after edge k with no roots.
- R4: Position p is a root when the sum over j of c_j·alpha^(p·j) is zero in the selected field.
- R5: The status word holds done in bit 0, busy in bit 1 and the root count in bits [15:8]. The count saturates at 255.
- R6: Root positions are stored in ascending order at indices 0, 1, ... up to 24 entries. Further roots are counted but not stored, and reading an index with no stored entry returns 0.
- R7: `uncorrectable` is high while done is set and the root count differs from the programmed degree.
- R8: Done stays set until the next `start` or `dis`. A new `start` reruns the search with the same coefficients.
- R9: Coefficient and configuration writes are ignored while the search is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dis | input | 1 | Disable pulse; clears the engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Configuration: degree [20:16], large-sector flag [0] |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 5 | Coefficient index |
| coef_data | input | 14 | Coefficient value |
| len_bits | input | 16 | Number of positions to search |
| start | input | 1 | Start pulse |
| status | output | 32 | done [0], busy [1], root count [15:8] |
| loc_idx | input | 5 | Location readout index |
| loc_data | output | 16 | 1-based location at `loc_idx`, 0 when empty |
| uncorrectable | output | 1 | Root count differs from degree after done |

## Verification
The hardest case to reach from the ports is a search that finds more roots than the location store can hold, followed by saturation of the root counter. A real locator polynomial of degree 24 or less cannot have that many roots. The bench reaches this case by clearing the engine with `dis` and searching with an all-zero polynomial, so every tested position is a root. Lengths of 30 and 300 then fill the store past its limit and drive the counter to saturation. Polynomials with chosen roots are built in the bench from products of (x + alpha^p). Roots are placed at position 1 and at the final position, and both fields are exercised.

// File: rtl/chien_pkg.sv
package chien_pkg;
    localparam int MW    = 14;
    localparam int TMAX  = 24;
    localparam int NC    = TMAX + 1;
    localparam int IW    = 5;
    localparam int LW    = 16;
    localparam int CW    = 8;

    typedef logic [MW-1:0] elem_t;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

    localparam elem_t POLY13 = 14'h001B;
    localparam elem_t POLY14 = 14'h0443;

    function automatic elem_t gf_xtime(elem_t v, logic big);
        elem_t r;
        if (big) r = {v[12:0], 1'b0} ^ (v[13] ? POLY14 : '0);
        else     r = {1'b0, v[11:0], 1'b0} ^ (v[12] ? POLY13 : '0);
        return r;
    endfunction

    function automatic elem_t gf_apow_mul(elem_t v, int k, logic big);
        elem_t r = v;
        for (int i = 0; i < NC; i++)
            if (i < k) r = gf_xtime(r, big);
        return r;
    endfunction
endpackage

// File: rtl/chien_eval.sv
module chien_eval
    import chien_pkg::*;
#(
    parameter int NTAP = NC,
    parameter int IDXW = IW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  elem_t           wr_data,
    input  logic            load,
    input  logic            step,
    input  logic [IDXW-1:0] deg,
    input  logic            big,
    output logic            root
);
    elem_t mask;
    elem_t work_nx [NTAP];
    elem_t work_q  [NTAP];

    assign mask = big ? '1 : {1'b0, {(MW-1){1'b1}}};

    generate
        for (genvar j = 0; j < NTAP; j++) begin : gen_tap
            elem_t coef_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 coef_q <= '0;
                else if (clr)                               coef_q <= '0;
                else if (wr_en && wr_idx == IDXW'(j))       coef_q <= wr_data;
            end

            always_comb work_nx[j] = gf_apow_mul(work_q[j], j, big);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     work_q[j] <= '0;
                else if (clr)   work_q[j] <= '0;
                else if (load)  work_q[j] <= (IDXW'(j) <= deg) ? (coef_q & mask) : '0;
                else if (step)  work_q[j] <= work_nx[j];
            end

            // R1: a tap above the degree stays zero while stepping
            p_idle_tap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (step && work_q[j] == '0) |=> (work_q[j] == '0));
        end
    endgenerate

    always_comb begin
        elem_t acc;
        acc = '0;
        for (int j = 0; j < NTAP; j++) acc = acc ^ work_nx[j];
        root = (acc == '0);
    end
endmodule

// File: rtl/chien_locstore.sv
module chien_locstore #(
    parameter int DEPTH = 24,
    parameter int POSW  = 16,
    parameter int IDXW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [POSW-1:0] pos,
    input  logic [IDXW-1:0] rd_idx,
    output logic [POSW-1:0] rd_data
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [FW-1:0]   fill_q;
    logic [POSW-1:0] ent_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               fill_q <= '0;
        else if (clr)                             fill_q <= '0;
        else if (wr && fill_q < FW'(DEPTH))       fill_q <= fill_q + 1'b1;
    end

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : gen_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       ent_q[e] <= '0;
                else if (clr)                     ent_q[e] <= '0;
                else if (wr && fill_q == FW'(e))  ent_q[e] <= pos;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < DEPTH; e++)
            if (rd_idx == IDXW'(e)) rd_data = ent_q[e];
    end

    // R6: the store never overfills and a full store stays full on a write
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FW'(DEPTH) && wr && !clr) |=> (fill_q == FW'(DEPTH)));
    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(DEPTH));
endmodule

// File: rtl/chien_locator.sv
module chien_locator
    import chien_pkg::*;
#(
    parameter int DEPTH = TMAX,
    parameter int LENW  = LW,
    parameter int CNTW  = CW
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dis,
    input  logic        cfg_we,
    input  logic [31:0] cfg_word,
    input  logic        coef_we,
    input  logic [4:0]  coef_idx,
    input  logic [13:0] coef_data,
    input  logic [15:0] len_bits,
    input  logic        start,
    output logic [31:0] status,
    input  logic [4:0]  loc_idx,
    output logic [15:0] loc_data,
    output logic        uncorrectable
);
    state_t          st_q, st_nx;
    logic [LENW-1:0] pos_q, len_q;
    logic [CNTW-1:0] cnt_q;
    logic [IW-1:0]   deg_q;
    logic            big_q;
    logic            go, step, root, hit, busy, done;
    logic            cfg_unused;

    assign cfg_unused = ^{cfg_word[31:21], cfg_word[15:1]};
    assign go   = start && !dis;
    assign busy = (st_q == S_RUN);
    assign done = (st_q == S_DONE);
    assign step = busy && !go && !dis;
    assign hit  = step && root;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deg_q <= '0;
            big_q <= 1'b0;
        end else if (cfg_we && !busy) begin
            deg_q <= cfg_word[20:16];
            big_q <= cfg_word[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: st_nx = S_IDLE;
            S_RUN:  if (pos_q == len_q) st_nx = S_DONE;
            S_DONE: st_nx = S_DONE;
            default: st_nx = S_IDLE;
        endcase
        if (start) st_nx = (len_bits == '0) ? S_DONE : S_RUN;
        if (dis)   st_nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else if (dis) begin
            cnt_q <= '0;
        end else if (go) begin
            pos_q <= LENW'(1);
            len_q <= len_bits;
            cnt_q <= '0;
        end else if (step) begin
            pos_q <= pos_q + 1'b1;
            if (root && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign status        = {16'h0, cnt_q, 6'h0, busy, done};
    assign uncorrectable = done && (cnt_q != CNTW'(deg_q));

    chien_eval u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dis),
        .wr_en   (coef_we && !busy),
        .wr_idx  (coef_idx),
        .wr_data (coef_data),
        .load    (go),
        .step    (step),
        .deg     (deg_q),
        .big     (big_q),
        .root    (root)
    );

    chien_locstore #(.DEPTH(DEPTH), .POSW(LENW), .IDXW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dis || go),
        .wr      (hit),
        .pos     (pos_q),
        .rd_idx  (loc_idx),
        .rd_data (loc_data)
    );

    // R2: disable empties the status word on the next cycle
    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (status == 32'h0));
    // R3: a start with non-zero length enters the busy phase with a fresh count
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dis && len_bits != '0) |=> (status[1] && status[15:8] == 8'h0));
    // R3: the tested position stays inside 1..len
    p_pos_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos_q >= LENW'(1) && pos_q <= len_q));
    // R8: done holds with a steady count until start or disable
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !start && !dis) |=> (status[0] && $stable(status[15:8])));
    // R5: a saturated count does not wrap
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !start && !dis) |=> (cnt_q == '1));
endmodule

// File: tb/sim_chien_locator.sv
module sim_chien_locator;
    localparam int NC = 25;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, dis = 1'b0, cfg_we = 1'b0, coef_we = 1'b0, start = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [4:0]  coef_idx = '0, loc_idx = '0;
    logic [13:0] coef_data = '0;
    logic [15:0] len_bits = '0;
    wire  [31:0] status;
    wire  [15:0] loc_data;
    wire         uncorrectable;

    chien_locator u0 (
        .clk(clk), .rst_n(rst_n), .dis(dis), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .len_bits(len_bits), .start(start), .status(status),
        .loc_idx(loc_idx), .loc_data(loc_data), .uncorrectable(uncorrectable)
    );

    int vec = 0, bad = 0;

    function automatic int gxt(int v, int big);
        if (big != 0) return ((v << 1) & 16'h3FFF) ^ (((v >> 13) & 1) != 0 ? 16'h0443 : 0);
        return ((v << 1) & 16'h1FFF) ^ (((v >> 12) & 1) != 0 ? 16'h001B : 0);
    endfunction

    function automatic int gmul(int a, int b, int big);
        int r = 0;
        for (int i = 13; i >= 0; i--) begin
            r = gxt(r, big);
            if (((b >> i) & 1) != 0) r = r ^ a;
        end
        return r;
    endfunction

    function automatic int apow(int p, int big);
        int v = 1;
        for (int i = 0; i < p; i++) v = gxt(v, big);
        return v;
    endfunction

    // behavioural reference
    int mst = 0, mdeg = 0, mbig = 0, mlen = 0, mpos = 0, mcnt = 0, mapow = 1;
    int mcoef [NC];
    int mwork [NC];
    int mlocs [$];

    always @(posedge clk) begin
        int ost;
        ost = mst;
        if (!rst_n) begin
            mst = 0; mdeg = 0; mbig = 0; mcnt = 0; mlocs.delete();
            for (int j = 0; j < NC; j++) begin mcoef[j] = 0; mwork[j] = 0; end
        end else begin
            if (dis) begin
                mst = 0; mcnt = 0; mlocs.delete();
                for (int j = 0; j < NC; j++) begin mcoef[j] = 0; mwork[j] = 0; end
            end else if (start) begin
                for (int j = 0; j < NC; j++)
                    mwork[j] = (j <= mdeg) ? (mcoef[j] & (mbig != 0 ? 16'h3FFF : 16'h1FFF)) : 0;
                mlen = len_bits; mcnt = 0; mlocs.delete(); mapow = 1; mpos = 1;
                mst = (len_bits == 0) ? 2 : 1;
            end else if (ost == 1) begin
                int v;
                mapow = gxt(mapow, mbig);
                v = 0;
                for (int j = NC - 1; j >= 0; j--) v = gmul(v, mapow, mbig) ^ mwork[j];
                if (v == 0) begin
                    if (mcnt < 255) mcnt++;
                    if (mlocs.size() < 24) mlocs.push_back(mpos);
                end
                if (mpos == mlen) mst = 2; else mpos++;
            end
            if (!dis && coef_we && ost != 1 && coef_idx < NC) mcoef[coef_idx] = coef_data;
            if (cfg_we && ost != 1) begin mdeg = cfg_word[20:16]; mbig = cfg_word[0]; end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int es, el;
        es = (mcnt << 8) | (mst == 1 ? 2 : 0) | (mst == 2 ? 1 : 0);
        el = (loc_idx < mlocs.size()) ? mlocs[loc_idx] : 0;
        chk(status == es, "R5 status word", status, es);
        chk(loc_data == el, "R6 location readout", loc_data, el);
        chk(uncorrectable == (mst == 2 && mcnt != mdeg), "R7 uncorrectable",
            uncorrectable, (mst == 2 && mcnt != mdeg));
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    int tc [NC];
    int troots [$];

    task automatic build(int big);
        int d = 0;
        for (int j = 0; j < NC; j++) tc[j] = 0;
        tc[0] = 1;
        foreach (troots[r]) begin
            int a;
            a = apow(troots[r], big);
            for (int j = d + 1; j >= 1; j--) tc[j] = tc[j-1] ^ gmul(tc[j], a, big);
            tc[0] = gmul(tc[0], a, big);
            d++;
        end
    endtask

    task automatic load(int deg, int big);
        dis = 1'b1; tick(); dis = 1'b0;
        cfg_word = (deg << 16) | big; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
        for (int j = 0; j <= deg; j++) begin
            coef_we = 1'b1; coef_idx = j[4:0]; coef_data = tc[j][13:0]; tick();
        end
        coef_we = 1'b0;
    endtask

    task automatic kick(int len);
        len_bits = len[15:0]; start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic search(int len, output int edges);
        kick(len);
        edges = 0;
        @(negedge clk);
        while (!status[0] && edges < 70000) begin
            @(posedge clk); edges++; @(negedge clk);
        end
        tick();
    endtask

    task automatic rd(int idx, output int val);
        loc_idx = idx[4:0]; @(negedge clk); val = loc_data; tick();
    endtask

    initial begin
        int e, v;
        tick(); tick();
        chk(status == 0, "R2 reset status", status, 0);
        rst_n = 1'b1; tick();

        // GF(2^13), 512-byte sector, t=4
        troots = '{5, 37, 200, 4100}; build(0); load(4, 0);
        search(512*8 + 13*4, e);
        chk(e == 4148, "R3 done timing", e, 4148);
        chk(status[15:8] == 4, "R4 root count", status[15:8], 4);
        rd(0, v); chk(v == 5, "R6 first location", v, 5);
        rd(3, v); chk(v == 4100, "R6 last location", v, 4100);
        rd(4, v); chk(v == 0, "R6 empty entry", v, 0);
        chk(uncorrectable == 0, "R7 consistent", uncorrectable, 0);

        // GF(2^14), 1024-byte sector, roots at both ends
        troots = '{1, 3000, 8220}; build(1); load(3, 1);
        search(1024*8 + 14*2, e);
        chk(status[15:8] == 3, "R1 large field count", status[15:8], 3);
        rd(0, v); chk(v == 1, "R4 root at position 1", v, 1);
        rd(2, v); chk(v == 8220, "R4 root at final position", v, 8220);

        // degree mask, busy-write ignore, sticky done, rerun
        troots = '{7}; build(0); load(1, 0);
        coef_we = 1'b1; coef_idx = 5'd3; coef_data = 14'h0155; tick(); coef_we = 1'b0;
        search(50, e);
        chk(status[15:8] == 1, "R1 taps above degree ignored", status[15:8], 1);
        kick(50); tick();
        coef_we = 1'b1; coef_idx = 5'd0; coef_data = 14'h1234; tick(); coef_we = 1'b0;
        for (int i = 0; i < 80; i++) tick();
        chk(status[0] == 1, "R8 done sticky", status[0], 1);
        search(50, e);
        rd(0, v); chk(v == 7, "R9 write while busy ignored", v, 7);

        // root count differs from degree
        troots = '{50, 60}; build(0); load(2, 0);
        search(40, e);
        chk(uncorrectable == 1, "R7 mismatch flagged", uncorrectable, 1);

        // zero polynomial: every position is a root
        dis = 1'b1; tick(); dis = 1'b0;
        cfg_word = 0; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
        search(30, e);
        chk(status[15:8] == 30, "R6 roots beyond store counted", status[15:8], 30);
        rd(23, v); chk(v == 24, "R6 last stored entry", v, 24);
        rd(24, v); chk(v == 0, "R6 beyond store reads zero", v, 0);
        search(300, e);
        chk(status[15:8] == 255, "R5 count saturates", status[15:8], 255);

        search(0, e);
        chk(e == 0 && status[15:8] == 0, "R3 zero length", e, 0);

        // disable during a run
        troots = '{7}; build(0); load(1, 0);
        kick(200);
        for (int i = 0; i < 10; i++) tick();
        dis = 1'b1; tick(); dis = 1'b0;
        chk(status == 0, "R2 disable clears status", status, 0);
        rd(0, v); chk(v == 0, "R2 disable clears locations", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule